// File: doc/BRIEF.md
# Five-to-Nine Repeating Sequence Counter

This block produces the repeating value pattern 5, 6, 7, 8, 9, 5, 6, ... and moves one step on every rising clock edge. The only inputs are a clock and a synchronous reset. The output is a 4-bit count. Designers use it wherever a small cyclic index with a non-zero base is needed, such as a slot pointer or a phase counter.

Internally a generic loadable counter holds the count. That counter has a synchronous clear, a parallel load that takes priority over counting, a count enable and a terminal-count flag. A small controller looks at the count and sorts it into one of three named phases:
- **ENTER**: the count is outside 5..9, or it is all ones. The controller asserts load with the constant 5. Transition ENTER→STEP happens on the next edge.
- **STEP**: the count is 5..8. The controller leaves load low, so the count increments. Transition STEP→STEP on 5..7, and STEP→WRAP when the count moves from 8 to 9.
- **WRAP**: the count is 9. The controller asserts load with 5. Transition WRAP→STEP happens on the next edge.

Count enable is held high at all times. After reset the count is 0, so the first edge after reset goes through ENTER.

Top module: `seq_five_to_nine`

## Requirements
- R1: While `rst` is high at a rising edge, `value` is 0 after that edge, and it stays 0 for as long as reset stays high.
- R2: At the first rising edge after `rst` falls, `value` changes from 0 to 5.
- R3: When `value` is 5, 6, 7 or 8 and `rst` is low at an edge, `value` grows by exactly 1 at that edge.
- R4: When `value` is 9 and `rst` is low at an edge, `value` becomes 5 at that edge.
- R5: From the first edge after reset is released, and until reset is asserted again, `value` only takes the values 5 to 9.
- R6: Reset takes priority over both reload and increment. An edge with `rst` high in any phase (including at 9) gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| value | output | 4 | Current count in the pattern |

## Verification
The bench focuses on three corner cases:
- **Reset exit.** A controller that did not treat 0 as out of range would count 1, 2, 3, 4 before it reached the pattern.
- **Wrap from 9.** A wrong bound would let 10 through or would cut the cycle short at 8.
- **Reset arriving mid-sequence, especially at 9.** If load were given priority over the clear, the result would be 5 instead of 0.

Random reset pulses placed at arbitrary points in the cycle sweep these cases across every phase, and a reference model checks every cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int unsigned CNT_W   = 4;
    localparam int unsigned LOW_VAL = 5;
    localparam int unsigned TOP_VAL = 9;

    typedef enum logic [1:0] {
        PH_ENTER = 2'd0,
        PH_STEP  = 2'd1,
        PH_WRAP  = 2'd2
    } phase_t;
endpackage

// File: rtl/seq_load_counter.sv
module seq_load_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         cnt_en,
    output logic [W-1:0] cnt,
    output logic         term
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    // state register: clear beats load, load beats increment
    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (load_en)
            cnt_q <= load_val;
        else if (cnt_en)
            cnt_q <= cnt_q + ONE;
    end

    always_comb begin
        cnt  = cnt_q;
        term = cnt_en && (cnt_q == ALL_ONES);
    end
endmodule

// File: rtl/seq_range_ctrl.sv
module seq_range_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned W  = 4,
    parameter int unsigned LO = 5,
    parameter int unsigned HI = 9
) (
    input  logic [W-1:0] cnt,
    input  logic         term,
    output logic         load_en,
    output logic [W-1:0] load_val,
    output logic         cnt_en,
    output phase_t       phase
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    // phase decode of the current count
    always_comb begin
        if (term || cnt < LO_V || cnt > HI_V)
            phase = PH_ENTER;
        else if (cnt == HI_V)
            phase = PH_WRAP;
        else
            phase = PH_STEP;
    end

    // output process: counter controls per phase
    always_comb begin
        load_val = LO_V;
        cnt_en   = 1'b1;
        unique case (phase)
            PH_ENTER: load_en = 1'b1;
            PH_WRAP:  load_en = 1'b1;
            PH_STEP:  load_en = 1'b0;
            default:  load_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/seq_five_to_nine.sv
module seq_five_to_nine
    import seq_pkg::*;
#(
    parameter int unsigned W  = CNT_W,
    parameter int unsigned LO = LOW_VAL,
    parameter int unsigned HI = TOP_VAL
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt;
    logic [W-1:0] load_val;
    logic         load_en;
    logic         cnt_en;
    logic         term;
    phase_t       phase;

    seq_load_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .clr      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_en   (cnt_en),
        .cnt      (cnt),
        .term     (term)
    );

    seq_range_ctrl #(.W(W), .LO(LO), .HI(HI)) u_ctrl (
        .cnt      (cnt),
        .term     (term),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_en   (cnt_en),
        .phase    (phase)
    );

    assign value = cnt;
endmodule

// File: rtl/seq_five_to_nine_chk.sv
module seq_five_to_nine_chk #(
    parameter int unsigned W  = 4,
    parameter int unsigned LO = 5,
    parameter int unsigned HI = 9
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] value
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (value == '0));  // R1

    AST_ENTRY_LOADS_LOW: assert property (@(posedge clk) disable iff (rst)
        (value == '0) |=> (value == LO_V));  // R2

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (value >= LO_V && value < HI_V) |=> (value == $past(value) + 1'b1));  // R3

    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (rst)
        (value == HI_V) |=> (value == LO_V));  // R4

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (value != '0) |-> (value >= LO_V && value <= HI_V));  // R5
endmodule

bind seq_five_to_nine seq_five_to_nine_chk #(.W(W), .LO(LO), .HI(HI)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .value (value)
);

// File: tb/test_seq_five_to_nine.sv
module test_seq_five_to_nine;
    logic       clk;
    logic       rst;
    logic [3:0] value;

    int unsigned n_checks;
    int unsigned n_fails;
    logic [3:0]  exp_val;
    bit          in_seq;
    bit          done;

    seq_five_to_nine i_seq_five_to_nine (
        .clk   (clk),
        .rst   (rst),
        .value (value)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [3:0] model_next(input logic [3:0] cur, input logic r);
        if (r) return 4'd0;
        if (cur == 4'd9 || cur < 4'd5 || cur > 4'd9) return 4'd5;
        return cur + 4'd1;
    endfunction

    function automatic string tag_for(input logic [3:0] cur, input logic r);
        if (r) return (cur == 4'd0) ? "R1" : "R6";
        if (cur == 4'd0) return "R2";
        if (cur == 4'd9) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: value=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock edge with reset level r; sampled 1 ns after the edge
    task automatic step(input logic r);
        logic [3:0] prev;
        string      tag;
        prev = exp_val;
        tag  = tag_for(prev, r);
        rst  = r;
        @(posedge clk);
        #1;
        exp_val = model_next(prev, r);
        check(tag, value, exp_val);
        if (r) in_seq = 1'b0;
        else begin
            if (in_seq) begin
                // R5: only 5..9 once the sequence is running
                n_checks++;
                if (value < 4'd5 || value > 4'd9) begin
                    n_fails++;
                    $display("FAIL R5: value=%0d expected=5..9 at %0t", value, $time);
                end
            end
            in_seq = 1'b1;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: value=%0d expected=completion", value);
        finish_up();
    end

    initial begin
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        in_seq   = 1'b0;
        exp_val  = 4'd0;
        rst      = 1'b1;
        void'($urandom(32'd20240611));
        #1;
        // R1: reset held several edges
        for (int i = 0; i < 3; i++) step(1'b1);
        check("R1", value, 4'd0);
        // R2, R3, R4: several full wraps
        for (int i = 0; i < 16; i++) step(1'b0);
        // R6: reset arriving while at 9
        while (exp_val != 4'd9) step(1'b0);
        step(1'b1);
        check("R6", value, 4'd0);
        step(1'b0);
        check("R2", value, 4'd5);
        // R6: reset arriving at 7
        while (exp_val != 4'd7) step(1'b0);
        step(1'b1);
        step(1'b0);
        // random reset pulses across all phases
        for (int i = 0; i < 600; i++) step(($urandom % 13) == 0);
        for (int i = 0; i < 10; i++) step(1'b0);
        finish_up();
    end
endmodule